// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This is a purely combinational datapath slice for a small 16-bit co-processor core. It looks at the current instruction word and recognises four bit-field instructions and one priority-encoder instruction. It computes the result word and the next condition flags within the same cycle. The register file sits outside the block. It supplies the source operand, the destination operand and the control word, and it writes the result back when the block reports a recognised instruction.

A field is described by the low byte of the control word. The low nibble is the position of the field's least significant bit. The next nibble holds the field length minus one, so a field is between 1 and 16 bits long. Any part of a field that would reach past bit 15 is cut off.

The field operations are:
- extract, which right-aligns the selected source bits;
- insert, which writes the low source bits into the destination field;
- insert-inverted, which writes the complemented source bits;
- insert-XNOR, which writes the XNOR of the source bits and the existing destination bits.

Find-first-one reports the index of the most significant set bit of the source operand.

Top module: `bitfield_unit`

## Requirements
- R1: A word whose bits 15:11 equal 0x0C, 0x0D, 0x0E or 0x0F and whose bits 1:0 equal 3 selects extract, insert, insert-inverted or insert-XNOR, in that order. Bits 10:2 are ignored, and `op_valid_o` is 1.
- R2: A word whose bits 15:11 equal 0x01 and whose bits 4:0 equal 0x10 selects find-first-one, and `op_valid_o` is 1.
- R3: Any other word gives `op_valid_o` = 0, `result_o` = `dst_i` and `flags_o` = `flags_i`.
- R4: The field starts at `ctrl_i[3:0]` and is `ctrl_i[7:4]`+1 bits long. The mask bits above bit 15 are discarded, and `ctrl_i[15:8]` has no effect.
- R5: Extract returns the source bits under the mask, shifted down to bit 0, with zeros above them.
- R6: Insert returns `dst_i` outside the mask and, inside it, `src_i` shifted left by the origin.
- R7: Insert-inverted behaves as R6 but writes the complement of the shifted source.
- R8: Insert-XNOR behaves as R6 but writes the XNOR of the shifted source and `dst_i`.
- R9: The flags use the layout bit 3 N, bit 2 Z, bit 1 V, bit 0 C. After a field operation, N is result bit 15, Z is set when the result is 0, V is 0 and C equals `flags_i[0]`.
- R10: Find-first-one returns the index of the highest set bit of `src_i` and clears C. A zero `src_i` gives result 0 with C set. N and V are 0, and Z is set when the returned index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word being executed |
| src_i | input | DATA_W | Source operand |
| dst_i | input | DATA_W | Destination operand (old value) |
| ctrl_i | input | DATA_W | Field control word (origin, length-1) |
| flags_i | input | 4 | Current N, Z, V, C |
| result_o | output | DATA_W | Result word |
| flags_o | output | 4 | Next N, Z, V, C |
| op_valid_o | output | 1 | Instruction recognised by this unit |

## Verification
The assertions check, at every input change, these properties:
- unrecognised words pass the destination operand and flags through unchanged;
- field operations clear V, preserve C and derive N and Z from the result;
- an extracted value never has bits above its field length;
- a find-first-one result always names a set bit with only zeros above it, or reports a zero operand with C set.

The exact bit placement of the three insert variants, and the clipping of fields that reach past bit 15, are shown only by the bench. The bench sweeps all 256 origin and length pairs against a bit-by-bit loop model with several operand patterns and noise in the upper control byte.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_EXT,
    OP_INS,
    OP_INSI,
    OP_INSX,
    OP_FFO
  } bfu_op_e;

  localparam logic [4:0] OPC_EXT  = 5'h0C;
  localparam logic [4:0] OPC_INS  = 5'h0D;
  localparam logic [4:0] OPC_INSI = 5'h0E;
  localparam logic [4:0] OPC_INSX = 5'h0F;
  localparam logic [4:0] OPC_FFO  = 5'h01;
  localparam logic [1:0] SUB_FIELD = 2'b11;
  localparam logic [4:0] SUB_FFO   = 5'h10;

  // flag bit positions inside the condition byte
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
  import bfu_pkg::*;
(
  input  logic [15:0] instr_i,
  output bfu_op_e     op_o
);
  logic [4:0] opc;
  logic       unused_mid;

  assign opc        = instr_i[15:11];
  assign unused_mid = ^instr_i[10:5];

  always_comb begin
    op_o = OP_NONE;
    if (instr_i[1:0] == SUB_FIELD) begin
      unique case (opc)
        OPC_EXT:  op_o = OP_EXT;
        OPC_INS:  op_o = OP_INS;
        OPC_INSI: op_o = OP_INSI;
        OPC_INSX: op_o = OP_INSX;
        default:  op_o = OP_NONE;
      endcase
    end
    if (opc == OPC_FFO && instr_i[4:0] == SUB_FFO) op_o = OP_FFO;
  end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = 16,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  origin_i,
  input  logic [POS_W-1:0]  len_m1_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [POS_W:0]  span;
  logic [DATA_W:0] ones_ext;

  assign span     = {1'b0, len_m1_i} + (POS_W+1)'(1);
  // one extra bit so a full-width field does not overflow
  assign ones_ext = ((DATA_W+1)'(1) << span) - (DATA_W+1)'(1);
  assign mask_o   = ones_ext[DATA_W-1:0] << origin_i;
endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  bfu_op_e           op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [POS_W-1:0]  origin_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] src_up;
  logic [DATA_W-1:0] ins_bits;

  assign src_up = src_i << origin_i;

  always_comb begin
    unique case (op_i)
      OP_INSI: ins_bits = ~src_up;
      OP_INSX: ins_bits = ~(src_up ^ dst_i);
      default: ins_bits = src_up;
    endcase
  end

  always_comb begin
    if (op_i == OP_EXT) res_o = (src_i & mask_i) >> origin_i;
    else                res_o = (dst_i & ~mask_i) | (ins_bits & mask_i);
  end
endmodule

// File: rtl/bfu_ffo.sv
module bfu_ffo #(
  parameter int DATA_W = 16,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] index_o,
  output logic              zero_o
);
  logic [POS_W-1:0] idx;

  // ascending scan: the last hit is the most significant one
  always_comb begin
    idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (operand_i[i]) idx = POS_W'(i);
    end
  end

  assign index_o = DATA_W'(idx);
  assign zero_o  = (operand_i == '0);
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              op_valid_o
);
  localparam int POS_W = $clog2(DATA_W);

  bfu_op_e           op;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] field_res;
  logic [DATA_W-1:0] ffo_idx;
  logic              ffo_zero;
  logic              unused_ctrl;

  assign unused_ctrl = ^ctrl_i[DATA_W-1:2*POS_W];

  bfu_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op)
  );

  bfu_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .origin_i (ctrl_i[POS_W-1:0]),
    .len_m1_i (ctrl_i[2*POS_W-1:POS_W]),
    .mask_o   (mask)
  );

  bfu_field_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i     (op),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .origin_i (ctrl_i[POS_W-1:0]),
    .mask_i   (mask),
    .res_o    (field_res)
  );

  bfu_ffo #(.DATA_W(DATA_W)) u_ffo (
    .operand_i (src_i),
    .index_o   (ffo_idx),
    .zero_o    (ffo_zero)
  );

  always_comb begin
    result_o = dst_i;
    flags_o  = flags_i;
    unique case (op)
      OP_NONE: ;
      OP_FFO: begin
        result_o       = ffo_idx;
        flags_o        = '0;
        flags_o[FLG_Z] = (ffo_idx == '0);
        flags_o[FLG_C] = ffo_zero;
      end
      default: begin
        result_o       = field_res;
        flags_o[FLG_N] = field_res[DATA_W-1];
        flags_o[FLG_Z] = (field_res == '0);
        flags_o[FLG_V] = 1'b0;
        flags_o[FLG_C] = flags_i[FLG_C];
      end
    endcase
  end

  assign op_valid_o = (op != OP_NONE);
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic [15:0]       instr_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] ctrl_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        flags_o,
  input logic              op_valid_o
);
  localparam int POS_W = $clog2(DATA_W);

  logic             is_field;
  logic             is_ext;
  logic             is_ffo;
  logic [POS_W-1:0] len_m1;
  logic             known;

  assign is_field = op_valid_o && (instr_i[15:13] == 3'b011);
  assign is_ext   = op_valid_o && (instr_i[15:11] == 5'h0C);
  assign is_ffo   = op_valid_o && (instr_i[15:11] == 5'h01);
  assign len_m1   = ctrl_i[2*POS_W-1:POS_W];
  assign known    = !$isunknown({instr_i, src_i, dst_i, ctrl_i, flags_i});

  always_comb begin
    if (known) begin
      // R3
      passthru_chk: assert (op_valid_o || (result_o == dst_i && flags_o == flags_i))
        else $error("unrecognised word altered outputs");
      // R9
      field_flags_chk: assert (!is_field || (flags_o[1] == 1'b0 && flags_o[0] == flags_i[0]
                               && flags_o[3] == result_o[DATA_W-1]
                               && flags_o[2] == (result_o == '0)))
        else $error("field op flags wrong");
      // R5
      ext_width_chk: assert (!is_ext || len_m1 == POS_W'(DATA_W-1)
                             || (result_o >> ({1'b0, len_m1} + (POS_W+1)'(1))) == '0)
        else $error("extract wider than field");
      // R10
      ffo_zero_chk: assert (!is_ffo || src_i != '0 || (result_o == '0 && flags_o[0]))
        else $error("zero operand not flagged");
      // R10
      ffo_hit_chk: assert (!is_ffo || src_i == '0
                           || (!flags_o[0] && src_i[result_o[POS_W-1:0]]
                               && ((src_i >> result_o[POS_W-1:0]) >> 1) == '0))
        else $error("find-first-one index wrong");
    end
  end
endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .instr_i    (instr_i),
  .src_i      (src_i),
  .dst_i      (dst_i),
  .ctrl_i     (ctrl_i),
  .flags_i    (flags_i),
  .result_o   (result_o),
  .flags_o    (flags_o),
  .op_valid_o (op_valid_o)
);

// File: tb/tb_bitfield_unit.sv
module tb_bitfield_unit;
  localparam int W = 16;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  instr_i = '0;
  logic [W-1:0] src_i = '0, dst_i = '0, ctrl_i = '0;
  logic [3:0]   flags_i = '0;
  logic [W-1:0] result_o;
  logic [3:0]   flags_o;
  logic         op_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bitfield_unit #(.DATA_W(W)) dut (
    .instr_i (instr_i), .src_i (src_i), .dst_i (dst_i), .ctrl_i (ctrl_i),
    .flags_i (flags_i), .result_o (result_o), .flags_o (flags_o),
    .op_valid_o (op_valid_o)
  );

  localparam logic [15:0] W_EXT  = 16'h6003;
  localparam logic [15:0] W_INS  = 16'h6803;
  localparam logic [15:0] W_INSI = 16'h7003;
  localparam logic [15:0] W_INSX = 16'h7803;
  localparam logic [15:0] W_FFO  = 16'h0810;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ins, input logic [W-1:0] s, input logic [W-1:0] d,
                       input logic [W-1:0] c, input logic [3:0] f);
    @(posedge clk);
    instr_i = ins; src_i = s; dst_i = d; ctrl_i = c; flags_i = f;
    #5;
  endtask

  function automatic logic [W-1:0] ref_field(input int kind, input logic [W-1:0] s,
                                              input logic [W-1:0] d, input logic [7:0] c);
    int o = int'(c[3:0]);
    int l = int'(c[7:4]);
    logic [W-1:0] r;
    if (kind == 0) begin
      r = '0;
      for (int j = 0; j < W; j++)
        if (j <= l && o + j < W) r[j] = s[o+j];
    end else begin
      r = d;
      for (int i = 0; i < W; i++) begin
        if (i >= o && i <= o + l) begin
          case (kind)
            1: r[i] = s[i-o];
            2: r[i] = ~s[i-o];
            default: r[i] = ~(s[i-o] ^ d[i]);
          endcase
        end
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_flags(input logic [W-1:0] r, input logic c);
    return {r[W-1], r == '0, 1'b0, c};
  endfunction

  task automatic t_idle();
    // R3: reset-time idle word 0 passes everything through
    apply(16'h0000, 16'h1234, 16'hBEEF, 16'h00FF, 4'b1011);
    check("R3 idle valid", 32'(op_valid_o), 32'd0);
    check("R3 idle result", 32'(result_o), 32'hBEEF);
    check("R3 idle flags", 32'(flags_o), 32'hB);
    apply(16'h6002, 16'hFFFF, 16'h0F0F, 16'h0033, 4'b0110);
    check("R3 wrong low bits", 32'(op_valid_o), 32'd0);
    check("R3 wrong low bits result", 32'(result_o), 32'h0F0F);
    check("R3 wrong low bits flags", 32'(flags_o), 32'h6);
    apply(16'h0811, 16'h8000, 16'h5555, 16'h0000, 4'b1111);
    check("R3 near ffo", 32'(op_valid_o), 32'd0);
    check("R3 near ffo result", 32'(result_o), 32'h5555);
  endtask

  task automatic t_decode();
    // R1: middle bits ignored, valid raised
    apply(W_EXT | 16'h07FC, 16'hABCD, 16'h0000, 16'h0034, 4'b0000);
    check("R1 ext valid", 32'(op_valid_o), 32'd1);
    check("R1 ext result", 32'(result_o), 32'(ref_field(0, 16'hABCD, 0, 8'h34)));
    apply(W_INSX | 16'h0324, 16'h0003, 16'h00F0, 16'h0014, 4'b0001);
    check("R1 insx valid", 32'(op_valid_o), 32'd1);
    // R2
    apply(W_FFO | 16'h0560, 16'h0400, 16'h1111, 16'h0000, 4'b0000);
    check("R2 ffo valid", 32'(op_valid_o), 32'd1);
    check("R2 ffo result", 32'(result_o), 32'd10);
  endtask

  task automatic t_sweep();
    logic [15:0] words[4];
    logic [W-1:0] pats[3];
    words = '{W_EXT, W_INS, W_INSI, W_INSX};
    pats  = '{16'hA5C3, 16'hFFFF, 16'h1E69};
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 256; c++) begin
        for (int p = 0; p < 3; p++) begin
          logic [W-1:0] s, d, e;
          logic [W-1:0] cw;
          logic cin;
          s   = pats[p];
          d   = ~pats[(p + 1) % 3] ^ 16'(c);
          cw  = {8'(c * 37 + p), 8'(c)}; // R4: upper byte is noise
          cin = 1'((c + p) & 1);
          apply(words[k], s, d, cw, {3'b010, cin});
          e = ref_field(k, s, d, 8'(c));
          case (k)
            0: check("R5 extract R4", 32'(result_o), 32'(e));
            1: check("R6 insert R4", 32'(result_o), 32'(e));
            2: check("R7 insert-inv R4", 32'(result_o), 32'(e));
            default: check("R8 insert-xnor R4", 32'(result_o), 32'(e));
          endcase
          check("R9 field flags", 32'(flags_o), 32'(ref_flags(e, cin)));
        end
      end
    end
  endtask

  task automatic t_edges();
    // R4: origin 12, length 8 -> only bits 15:12 used
    apply(W_INS, 16'h00FF, 16'h0123, 16'h0070 | 16'h000C, 4'b0000);
    check("R4 clip insert", 32'(result_o), 32'hF123);
    apply(W_EXT, 16'hF000, 16'h0000, 16'h007C, 4'b0000);
    check("R4 clip extract", 32'(result_o), 32'h000F);
    // R5: full width extract at origin 0
    apply(W_EXT, 16'h8001, 16'h0000, 16'h00F0, 4'b0001);
    check("R5 full", 32'(result_o), 32'h8001);
    check("R9 N set C kept", 32'(flags_o), 32'h9);
    // R9: zero result sets Z, carry clear kept
    apply(W_EXT, 16'h0F0F, 16'h0000, 16'h0034, 4'b1110);
    check("R9 zero", 32'(flags_o), 32'h4);
  endtask

  task automatic t_ffo();
    // R10
    apply(W_FFO, 16'h0000, 16'hAAAA, 16'h0000, 4'b1010);
    check("R10 zero result", 32'(result_o), 32'd0);
    check("R10 zero flags", 32'(flags_o), 32'h5);
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] v;
      v = (16'(1) << b) | (16'(1) << (b / 2));
      apply(W_FFO, v, 16'h0000, 16'h0000, 4'b0001);
      check("R10 index", 32'(result_o), 32'(b));
      check("R10 flags", 32'(flags_o), (b == 0) ? 32'h4 : 32'h0);
    end
  endtask

  initial begin
    #(20 * WATCHDOG);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_decode();
    t_edges();
    t_ffo();
    t_sweep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule